// File: doc/BRIEF.md
# Tamper Security State Controller

This block holds the security condition of a battery-backed tamper monitor. It latches digital event pulses from nine individually enabled sources (sensor tampers, external tamper inputs, external boot, and overflow of the time and monotonic counters). It raises a security-violation flag whenever an enabled source fires. While that flag is set, it holds a freeze output that stops the timekeeper. A separate not-valid flag marks state that cannot be trusted. The battery-domain reset always sets it, and a system reset sets it when the unit is in violation.

Software recovers the unit through write-one-to-clear accesses, and the block enforces the order of that recovery. The tamper enables must be zero before any detect bit can be cleared. The violation flag can be cleared only when the not-valid flag is set, every enable and detect bit is zero, and the failure hard lock is clear. The not-valid flag can be cleared only after the violation flag is already clear.

Three set-only lock bits protect the configuration. A soft configuration lock is released by a system reset. A hard configuration lock and a failure hard lock are released only by the battery-domain reset. The system reset is sampled on the clock. The battery-domain reset is asynchronous.

Top module: `tmon_sec_ctrl`

## Requirements
- R1: While `rst_bat_n` is low, and on the first sample after it rises, `nvf_o`=1, `svf_o`=0, `det_o`=0, `en_o`=0, `lock_o`=0 and `irq_o`=0.
- R2: A pulse on `event_i[i]` with `en_o[i]`=1 sets `det_o[i]` and `svf_o` on the next clock edge. A pulse on a source whose enable is 0 changes neither.
- R3: Detect bits and `svf_o` stay set until an accepted clear. `freeze_o` is high exactly while `svf_o` is high.
- R4: `irq_o` is high when `svf_o` and the interrupt enable (written through `irq_en_we`/`irq_en_wdata`) are both 1. A system reset clears the interrupt enable.
- R5: `lock_o` bit 0 is the soft configuration lock and bit 1 is the hard configuration lock. A `cfg_we` write to the enables is ignored while either bit is set. A system reset clears bit 0 only. Only the battery-domain reset clears bit 1.
- R6: A `lock_we` write ORs `lock_wdata` into `lock_o`, so writing zeros never clears a lock bit.
- R7: A system reset taken while `svf_o`=1 and `lock_o` bit 2 (failure hard lock)=0 sets `nvf_o`. A system reset leaves `nvf_o` unchanged in every other case.
- R8: `clr_we` with `clr_det[i]`=1 clears `det_o[i]` only if `en_o[i]`=0. Otherwise the clear is ignored.
- R9: `clr_we` with `clr_svf`=1 clears `svf_o` only when `nvf_o`=1, `lock_o` bit 2=0, `en_o`=0 and `det_o`=0. In every other case `svf_o` stays set.
- R10: `clr_we` with `clr_nvf`=1 clears `nvf_o` only when `svf_o` is already 0. The attempt is ignored while `svf_o`=1, including the cycle in which `svf_o` itself is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_bat_n | input | 1 | Battery-domain reset, asynchronous, active low |
| rst_sys_n | input | 1 | System reset, sampled on the clock, active low |
| event_i | input | N_SRC | One pulse line per event source |
| cfg_we | input | 1 | Write strobe for the source enables |
| cfg_en_wdata | input | N_SRC | New source enable vector |
| lock_we | input | 1 | Write strobe for the lock bits (set-only) |
| lock_wdata | input | 3 | Lock bits to set: 0 soft cfg, 1 hard cfg, 2 failure hard |
| irq_en_we | input | 1 | Write strobe for the violation interrupt enable |
| irq_en_wdata | input | 1 | New violation interrupt enable |
| clr_we | input | 1 | Write-one-to-clear strobe for status |
| clr_det | input | N_SRC | Detect bits to clear |
| clr_svf | input | 1 | Request to clear the violation flag |
| clr_nvf | input | 1 | Request to clear the not-valid flag |
| det_o | output | N_SRC | Sticky detect bits |
| en_o | output | N_SRC | Current source enables |
| lock_o | output | 3 | Current lock bits |
| svf_o | output | 1 | Security-violation flag |
| nvf_o | output | 1 | Not-valid flag |
| irq_o | output | 1 | Security-violation interrupt |
| freeze_o | output | 1 | Stops the timekeeper while in violation |

## Verification
The assertions check several properties on every cycle. An enabled event always reaches the detect bits and the violation flag. Detect bits never drop without a clear strobe. Locked enables never move. Lock bits never fall outside a system reset. The violation flag falls only after its full qualifier held. The not-valid flag falls only from a non-violation state. A system reset always leaves the interrupt low. Other behaviours can be shown only by the bench's scenarios: the full recovery sequence in order, refused clears in each wrong order, the difference between the soft and hard configuration locks across a system reset, and a failure hard lock that keeps a system reset from entering not-valid.

// File: rtl/tmon_pkg.sv
package tmon_pkg;
    localparam int LOCK_W       = 3;
    localparam int LK_CFG_SOFT  = 0;
    localparam int LK_CFG_HARD  = 1;
    localparam int LK_FAIL_HARD = 2;
    typedef logic [LOCK_W-1:0] lock_vec_t;
endpackage

// File: rtl/tmon_cfg_regs.sv
module tmon_cfg_regs
    import tmon_pkg::*;
#(
    parameter int N_SRC = 9
) (
    input  logic             clk,
    input  logic             rst_bat_n,
    input  logic             sys_rst,
    input  logic             cfg_we,
    input  logic [N_SRC-1:0] cfg_wdata,
    input  logic             lock_we,
    input  lock_vec_t        lock_wdata,
    output logic [N_SRC-1:0] en_o,
    output lock_vec_t        lock_o
);
    typedef struct packed {
        logic [N_SRC-1:0] en;
        lock_vec_t        lock;
    } cfg_st_t;

    cfg_st_t st_d, st_q;
    logic    cfg_blocked;

    always_comb begin
        st_d        = st_q;
        cfg_blocked = st_q.lock[LK_CFG_SOFT] | st_q.lock[LK_CFG_HARD];
        if (sys_rst) begin
            st_d.lock[LK_CFG_SOFT] = 1'b0;
        end else begin
            if (cfg_we && !cfg_blocked) st_d.en = cfg_wdata;
            if (lock_we) st_d.lock = st_q.lock | lock_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_bat_n) begin
        if (!rst_bat_n) st_q <= '0;
        else            st_q <= st_d;
    end

    assign en_o   = st_q.en;
    assign lock_o = st_q.lock;

    // R5: a locked configuration never changes
    assert_cfg_locked_R5: assert property (@(posedge clk) disable iff (!rst_bat_n)
        (st_q.lock[LK_CFG_SOFT] || st_q.lock[LK_CFG_HARD]) |=> $stable(st_q.en));
    // R6: outside a system reset lock bits only rise
    assert_lock_setonly_R6: assert property (@(posedge clk) disable iff (!rst_bat_n)
        !sys_rst |=> ((st_q.lock & $past(st_q.lock)) == $past(st_q.lock)));
    // R5: hard lock survives a system reset
    assert_hard_keep_R5: assert property (@(posedge clk) disable iff (!rst_bat_n)
        (sys_rst && st_q.lock[LK_CFG_HARD]) |=> st_q.lock[LK_CFG_HARD]);
endmodule

// File: rtl/tmon_det_latch.sv
module tmon_det_latch #(
    parameter int N_SRC = 9
) (
    input  logic             clk,
    input  logic             rst_bat_n,
    input  logic             sys_rst,
    input  logic [N_SRC-1:0] event_i,
    input  logic [N_SRC-1:0] en_i,
    input  logic             clr_we,
    input  logic [N_SRC-1:0] clr_det,
    output logic [N_SRC-1:0] det_o,
    output logic             hit_o
);
    typedef struct packed {
        logic [N_SRC-1:0] det;
    } det_st_t;

    det_st_t          st_d, st_q;
    logic [N_SRC-1:0] set_v, clr_v;

    for (genvar i = 0; i < N_SRC; i++) begin : g_src
        assign set_v[i] = event_i[i] & en_i[i];
        assign clr_v[i] = clr_we & !sys_rst & clr_det[i] & !en_i[i];
    end

    always_comb begin
        st_d     = st_q;
        st_d.det = (st_q.det & ~clr_v) | set_v;
    end

    always_ff @(posedge clk or negedge rst_bat_n) begin
        if (!rst_bat_n) st_q <= '0;
        else            st_q <= st_d;
    end

    assign det_o = st_q.det;
    assign hit_o = |set_v;

    // R2: every enabled event lands in its detect bit
    assert_det_set_R2: assert property (@(posedge clk) disable iff (!rst_bat_n)
        |(event_i & en_i) |=> ((st_q.det & $past(event_i & en_i)) == $past(event_i & en_i)));
    // R3: without a clear strobe no detect bit falls
    assert_det_sticky_R3: assert property (@(posedge clk) disable iff (!rst_bat_n)
        !clr_we |=> ((st_q.det & $past(st_q.det)) == $past(st_q.det)));
endmodule

// File: rtl/tmon_sec_ctrl.sv
module tmon_sec_ctrl
    import tmon_pkg::*;
#(
    parameter int N_SRC = 9
) (
    input  logic             clk,
    input  logic             rst_bat_n,
    input  logic             rst_sys_n,
    input  logic [N_SRC-1:0] event_i,
    input  logic             cfg_we,
    input  logic [N_SRC-1:0] cfg_en_wdata,
    input  logic             lock_we,
    input  logic [2:0]       lock_wdata,
    input  logic             irq_en_we,
    input  logic             irq_en_wdata,
    input  logic             clr_we,
    input  logic [N_SRC-1:0] clr_det,
    input  logic             clr_svf,
    input  logic             clr_nvf,
    output logic [N_SRC-1:0] det_o,
    output logic [N_SRC-1:0] en_o,
    output logic [2:0]       lock_o,
    output logic             svf_o,
    output logic             nvf_o,
    output logic             irq_o,
    output logic             freeze_o
);
    typedef struct packed {
        logic svf;
        logic nvf;
        logic irq_en;
    } sec_st_t;

    sec_st_t          st_d, st_q;
    logic             sys_rst;
    logic             hit_w;
    logic [N_SRC-1:0] en_w, det_w;
    lock_vec_t        lock_w;
    logic             svf_clr_ok, nvf_clr_ok;

    assign sys_rst = !rst_sys_n;

    tmon_cfg_regs #(.N_SRC(N_SRC)) cfg_i (
        .clk        (clk),
        .rst_bat_n  (rst_bat_n),
        .sys_rst    (sys_rst),
        .cfg_we     (cfg_we),
        .cfg_wdata  (cfg_en_wdata),
        .lock_we    (lock_we),
        .lock_wdata (lock_wdata),
        .en_o       (en_w),
        .lock_o     (lock_w)
    );

    tmon_det_latch #(.N_SRC(N_SRC)) det_i (
        .clk       (clk),
        .rst_bat_n (rst_bat_n),
        .sys_rst   (sys_rst),
        .event_i   (event_i),
        .en_i      (en_w),
        .clr_we    (clr_we),
        .clr_det   (clr_det),
        .det_o     (det_w),
        .hit_o     (hit_w)
    );

    always_comb begin
        st_d       = st_q;
        svf_clr_ok = st_q.nvf && !lock_w[LK_FAIL_HARD] && (en_w == '0) && (det_w == '0);
        nvf_clr_ok = !st_q.svf;
        if (sys_rst) begin
            st_d.irq_en = 1'b0;
            if (st_q.svf && !lock_w[LK_FAIL_HARD]) st_d.nvf = 1'b1;
        end else begin
            if (irq_en_we) st_d.irq_en = irq_en_wdata;
            if (clr_we && clr_svf && svf_clr_ok) st_d.svf = 1'b0;
            if (clr_we && clr_nvf && nvf_clr_ok) st_d.nvf = 1'b0;
        end
        if (hit_w) st_d.svf = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_bat_n) begin
        if (!rst_bat_n) st_q <= '{svf: 1'b0, nvf: 1'b1, irq_en: 1'b0};
        else            st_q <= st_d;
    end

    assign det_o    = det_w;
    assign en_o     = en_w;
    assign lock_o   = lock_w;
    assign svf_o    = st_q.svf;
    assign nvf_o    = st_q.nvf;
    assign irq_o    = st_q.svf & st_q.irq_en;
    assign freeze_o = st_q.svf;

    // R2: an enabled event always raises the violation flag
    assert_svf_on_hit_R2: assert property (@(posedge clk) disable iff (!rst_bat_n)
        hit_w |=> st_q.svf);
    // R9: the violation flag falls only after its full qualifier held
    assert_svf_clear_R9: assert property (@(posedge clk) disable iff (!rst_bat_n)
        $fell(st_q.svf) |-> ($past(st_q.nvf) && !$past(lock_w[LK_FAIL_HARD])
                             && ($past(en_w) == '0) && ($past(det_w) == '0)));
    // R10: not-valid falls only from a non-violation state
    assert_nvf_order_R10: assert property (@(posedge clk) disable iff (!rst_bat_n)
        $fell(st_q.nvf) |-> !$past(st_q.svf));
    // R4: a system reset leaves the interrupt low
    assert_irq_sysrst_R4: assert property (@(posedge clk) disable iff (!rst_bat_n)
        sys_rst |=> !irq_o);
    // R7: system reset in violation without failure hard lock enters not-valid
    assert_nvf_enter_R7: assert property (@(posedge clk) disable iff (!rst_bat_n)
        (sys_rst && st_q.svf && !lock_w[LK_FAIL_HARD]) |=> st_q.nvf);
endmodule

// File: tb/tmon_sec_ctrl_tb.sv
module tmon_sec_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int N = 9;

    logic         clk = 1'b0;
    logic         rst_bat_n = 1'b0, rst_sys_n = 1'b1;
    logic [N-1:0] event_i = '0, cfg_en_wdata = '0, clr_det = '0;
    logic         cfg_we = 0, lock_we = 0, irq_en_we = 0, irq_en_wdata = 0;
    logic         clr_we = 0, clr_svf = 0, clr_nvf = 0;
    logic [2:0]   lock_wdata = '0;
    logic [N-1:0] det_o, en_o;
    logic [2:0]   lock_o;
    logic         svf_o, nvf_o, irq_o, freeze_o;

    int checks = 0, failures = 0, cycles = 0;

    // behavioural reference state
    bit [N-1:0] m_en, m_det;
    bit [2:0]   m_lock;
    bit         m_svf, m_nvf, m_irqen;

    always #(CLK_PERIOD/2) clk = ~clk;

    tmon_sec_ctrl #(.N_SRC(N)) dut_i (
        .clk(clk), .rst_bat_n(rst_bat_n), .rst_sys_n(rst_sys_n), .event_i(event_i),
        .cfg_we(cfg_we), .cfg_en_wdata(cfg_en_wdata), .lock_we(lock_we), .lock_wdata(lock_wdata),
        .irq_en_we(irq_en_we), .irq_en_wdata(irq_en_wdata), .clr_we(clr_we), .clr_det(clr_det),
        .clr_svf(clr_svf), .clr_nvf(clr_nvf), .det_o(det_o), .en_o(en_o), .lock_o(lock_o),
        .svf_o(svf_o), .nvf_o(nvf_o), .irq_o(irq_o), .freeze_o(freeze_o));

    always @(posedge clk or negedge rst_bat_n) begin
        bit         hit, ok_svf;
        bit [N-1:0] nd;
        if (!rst_bat_n) begin
            m_en <= '0; m_det <= '0; m_lock <= '0; m_svf <= 0; m_nvf <= 1; m_irqen <= 0;
        end else begin
            hit = 0;
            nd  = m_det;
            for (int i = 0; i < N; i++) begin
                if (event_i[i] && m_en[i]) begin nd[i] = 1; hit = 1; end
                else if (rst_sys_n && clr_we && clr_det[i] && !m_en[i]) nd[i] = 0;
            end
            m_det <= nd;
            if (!rst_sys_n) begin
                m_lock[0] <= 0;
                m_irqen   <= 0;
                if (m_svf && !m_lock[2]) m_nvf <= 1;
                if (hit) m_svf <= 1;
            end else begin
                if (cfg_we && m_lock[1:0] == 2'b00) m_en <= cfg_en_wdata;
                if (lock_we) m_lock <= m_lock | lock_wdata;
                if (irq_en_we) m_irqen <= irq_en_wdata;
                ok_svf = m_nvf && !m_lock[2] && m_en == 0 && m_det == 0;
                if (hit) m_svf <= 1;
                else if (clr_we && clr_svf && ok_svf) m_svf <= 0;
                if (clr_we && clr_nvf && !m_svf) m_nvf <= 0;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cmp_model();
        chk(det_o == m_det, "R2 model det", det_o, m_det);
        chk(en_o == m_en, "R5 model en", en_o, m_en);
        chk(lock_o == m_lock, "R6 model lock", lock_o, m_lock);
        chk(svf_o == m_svf, "R9 model svf", svf_o, m_svf);
        chk(nvf_o == m_nvf, "R10 model nvf", nvf_o, m_nvf);
        chk(irq_o == (m_svf && m_irqen), "R4 model irq", irq_o, m_svf && m_irqen);
        chk(freeze_o == m_svf, "R3 model freeze", freeze_o, m_svf);
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        cmp_model();
        event_i = '0; cfg_we = 0; lock_we = 0; irq_en_we = 0;
        clr_we = 0; clr_det = '0; clr_svf = 0; clr_nvf = 0;
    endtask

    task automatic sys_reset();
        rst_sys_n = 0; step(); rst_sys_n = 1;
    endtask

    task automatic bat_reset();
        rst_bat_n = 0; step(); step(); rst_bat_n = 1; step();
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000) begin
            failures++; checks++;
            $display("FAIL watchdog actual=%0d expected=done", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        bat_reset();
        // R1 reset state
        chk(nvf_o == 1 && svf_o == 0 && det_o == 0 && en_o == 0 && lock_o == 0 && irq_o == 0,
            "R1 reset state", {nvf_o, svf_o, irq_o}, 3'b100);
        clr_we = 1; clr_nvf = 1; step();
        chk(nvf_o == 0, "R10 nvf clear accepted", nvf_o, 0);
        cfg_we = 1; cfg_en_wdata = 9'h005; step();
        chk(en_o == 9'h005, "R5 unlocked write", en_o, 9'h005);
        event_i = 9'h002; step();
        chk(det_o == 0 && svf_o == 0, "R2 disabled source ignored", {det_o, svf_o}, 0);
        event_i = 9'h004; step();
        chk(det_o == 9'h004 && svf_o == 1 && freeze_o == 1, "R2 enabled source", {det_o, svf_o}, {9'h004, 1'b1});
        step();
        chk(det_o == 9'h004 && svf_o == 1, "R3 sticky", {det_o, svf_o}, {9'h004, 1'b1});
        chk(irq_o == 0, "R4 irq disabled", irq_o, 0);
        irq_en_we = 1; irq_en_wdata = 1; step();
        chk(irq_o == 1, "R4 irq enabled", irq_o, 1);
        clr_we = 1; clr_svf = 1; step();
        chk(svf_o == 1, "R9 clear refused nvf low", svf_o, 1);
        clr_we = 1; clr_det = 9'h004; step();
        chk(det_o == 9'h004, "R8 clear refused enabled", det_o, 9'h004);
        lock_we = 1; lock_wdata = 3'b001; step();
        cfg_we = 1; cfg_en_wdata = '0; step();
        chk(en_o == 9'h005, "R5 soft lock blocks", en_o, 9'h005);
        lock_we = 1; lock_wdata = 3'b000; step();
        chk(lock_o == 3'b001, "R6 set only", lock_o, 3'b001);
        sys_reset();
        chk(irq_o == 0, "R4 sys reset clears irq enable", irq_o, 0);
        chk(lock_o == 3'b000, "R5 soft lock released", lock_o, 0);
        chk(nvf_o == 1 && svf_o == 1, "R7 enter nvf+svf", {nvf_o, svf_o}, 2'b11);
        clr_we = 1; clr_svf = 1; step();
        chk(svf_o == 1, "R9 clear refused enables set", svf_o, 1);
        cfg_we = 1; cfg_en_wdata = '0; step();
        clr_we = 1; clr_det = 9'h1FF; step();
        chk(det_o == 0, "R8 clear accepted", det_o, 0);
        clr_we = 1; clr_nvf = 1; step();
        chk(nvf_o == 1, "R10 clear refused svf set", nvf_o, 1);
        clr_we = 1; clr_svf = 1; clr_nvf = 1; step();
        chk(svf_o == 0 && nvf_o == 1, "R10 same-cycle order", {svf_o, nvf_o}, 2'b01);
        chk(freeze_o == 0, "R9 freeze released", freeze_o, 0);
        clr_we = 1; clr_nvf = 1; step();
        chk(nvf_o == 0, "R10 valid again", nvf_o, 0);
        lock_we = 1; lock_wdata = 3'b010; step();
        sys_reset();
        chk(lock_o == 3'b010, "R5 hard lock kept", lock_o, 3'b010);
        chk(nvf_o == 0, "R7 no svf no nvf", nvf_o, 0);
        cfg_we = 1; cfg_en_wdata = 9'h0FF; step();
        chk(en_o == 0, "R5 hard lock blocks", en_o, 0);
        bat_reset();
        chk(lock_o == 0 && nvf_o == 1, "R1 battery reset", {lock_o, nvf_o}, 4'b0001);
        clr_we = 1; clr_nvf = 1; step();
        cfg_we = 1; cfg_en_wdata = 9'h101; lock_we = 1; lock_wdata = 3'b100; step();
        event_i = 9'h100; step();
        chk(svf_o == 1 && det_o == 9'h100, "R2 top source", det_o, 9'h100);
        sys_reset();
        chk(nvf_o == 0, "R7 fail hard lock blocks nvf", nvf_o, 0);
        cfg_we = 1; cfg_en_wdata = '0; step();
        clr_we = 1; clr_det = 9'h1FF; step();
        clr_we = 1; clr_svf = 1; step();
        chk(svf_o == 1, "R9 refused under fail hard lock", svf_o, 1);
        step();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule